// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block is the part of an 8-bit processor core that owns the stack pointer, the interrupt-disable flag and every multi-cycle memory sequence that touches the stack. The instruction decoder hands it one command at a time: subroutine call, subroutine return, interrupt return, software break, push, pull, pull-status, set-I or clear-I. At each instruction boundary the decoder also raises a strobe, and the block then decides whether a pending interrupt request is taken. The block drives a byte-wide memory bus with one access per cycle. When a sequence produces a new program counter or status byte, it hands that value back on a one-cycle load strobe.

After reset the block reads the reset vector and publishes it as the first program counter. Hardware and software interrupt entries run the same seven-cycle sequence. They differ in the return address that is pushed and in the break bit of the stacked status byte. The three instructions that change the I flag (set-I, clear-I and pull-status) postpone their effect on interrupt recognition by one boundary. Instructions that return from an interrupt do not.

Top module: `stack_irq_seq`

## Requirements
- R1: A push writes to address 0x0100+S and then decrements S. A pull first increments S and then reads 0x0100+S. S wraps modulo 256, and S never changes in a cycle when the block is idle.
- R2: While reset is held and just after it, S reads 0xFD, I reads 1 and busy is high. The block reads 0xFFFC and then 0xFFFD. In the first idle cycle it pulses pc_load with pc_out equal to {byte at 0xFFFD, byte at 0xFFFC}.
- R3: A hardware interrupt is taken when the block is idle, boundary and irq are both high, and recognition is allowed. It keeps busy high for exactly 7 cycles. It writes pc_in high, pc_in low and then the status byte in busy cycles 2, 3 and 4 (counting from 0). It reads the vector at 0xFFFE/0xFFFF, pulses pc_load with that vector, and leaves I at 1.
- R4: Command 4 (break) runs the same 7-cycle sequence. The PC it pushes is pc_in+1, and the stacked status byte has bit 4 set.
- R5: The stacked status byte is {N,V,1,B,D,I,Z,C} from bit 7 down to bit 0. The flags_in bits are {N,V,D,Z,C} from bit 4 down to bit 0. I is the current internal flag. B is 0 for a hardware interrupt and 1 for a break.
- R6: Command 1 (call) pushes pc_in-1, high byte first, in two busy cycles. It then pulses pc_load with cmd_target.
- R7: Command 2 (subroutine return) pulls the low byte and then the high byte in two busy cycles. It then pulses pc_load with that value plus 1, modulo 2^16.
- R8: Command 3 (interrupt return) pulls the status byte, then the PC low byte, then the PC high byte, in three busy cycles. status_load shows the restored byte with bit 5 forced to 1 and bit 4 forced to 0. I takes the pulled bit 2 at once, with no recognition delay. pc_load carries the pulled PC with no increment.
- R9: Command 5 pushes cmd_data in one busy cycle. Command 6 pulls one byte in one busy cycle and presents it on pull_data with a pull_valid pulse in the next cycle.
- R10: Commands 8 (set I), 9 (clear I) and 7 (pull status) change I. At the next boundary only, recognition uses the I value from before that command. Later boundaries use the current I.
- R11: irq is a level that is sampled only when boundary is high and the block is idle. With I set, with boundary low, or with irq low, no entry starts. An entry that is taken wins over a command presented in the same cycle, and that command is dropped.
- R12: Command 7 (pull status) pulls one byte in one busy cycle. In the next cycle it pulses status_load with the byte restored as in R8, and it loads I from pulled bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present; taken only while idle |
| cmd_op | input | 4 | Command code (see requirements) |
| cmd_target | input | 16 | Destination of a subroutine call |
| cmd_data | input | 8 | Byte to push |
| pc_in | input | 16 | Address of the next instruction |
| flags_in | input | 5 | Current {N,V,D,Z,C} |
| irq | input | 1 | Level interrupt request |
| boundary | input | 1 | Instruction boundary strobe |
| mem_rdata | input | 8 | Read data, valid in the cycle of the address |
| busy | output | 1 | A sequence is running |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write enable |
| mem_wdata | output | 8 | Write data |
| pc_load | output | 1 | One-cycle strobe: pc_out is the new PC |
| pc_out | output | 16 | New program counter |
| status_load | output | 1 | One-cycle strobe: status_out is restored |
| status_out | output | 8 | Restored status byte |
| pull_valid | output | 1 | One-cycle strobe for pull_data |
| pull_data | output | 8 | Byte from a plain pull |
| sp | output | 8 | Stack pointer |
| i_flag | output | 1 | Interrupt-disable flag |

## Verification
The bench targets the recognition delay in all its forms. It sets I from clear and from set, pulls status with bit 2 in both states, and then offers a pending request at two successive boundaries. A design that used the new I value would take or refuse the wrong boundary, and that shows up as a busy window that is missing or unexpected. A full sweep of 256 pushes followed by 256 pulls carries S through its wrap. A design whose push and decrement are in the wrong order would return bytes one slot off. Calls at PCs 0x0000 and 0xFFFF exercise the minus-one and plus-one wraps. Break and hardware entries swept over the flag patterns show any wrong byte order or wrong B bit in the three stacked bytes. Returns from interrupt with I restored clear check that recognition is not delayed.

// File: rtl/sis_pkg.sv
package sis_pkg;

    typedef enum logic [3:0] {
        OP_NONE   = 4'd0,
        OP_CALL   = 4'd1,
        OP_RSUB   = 4'd2,
        OP_RINT   = 4'd3,
        OP_BRK    = 4'd4,
        OP_PUSH   = 4'd5,
        OP_PULL   = 4'd6,
        OP_PULLST = 4'd7,
        OP_SETI   = 4'd8,
        OP_CLRI   = 4'd9
    } sis_op_e;

    typedef enum logic [4:0] {
        ST_IDLE, ST_RV_LO, ST_RV_HI,
        ST_EN_D1, ST_EN_D2, ST_EN_PH, ST_EN_PL, ST_EN_PS, ST_EN_VL, ST_EN_VH,
        ST_CL_H, ST_CL_L,
        ST_PO_S, ST_PO_L, ST_PO_H,
        ST_PUSH, ST_PULL, ST_PLP
    } sis_st_e;

    typedef struct packed {
        sis_st_e     st;
        logic [7:0]  sp;
        logic [15:0] pc_keep;
        logic [15:0] tgt;
        logic [7:0]  byte_keep;
        logic [7:0]  lo;
        logic        i;
        logic        i_old;
        logic        dly;
        logic        add1;
        logic        pc_load;
        logic [15:0] pc_out;
        logic        st_load;
        logic [7:0]  st_out;
        logic        pull_v;
        logic [7:0]  pull_d;
    } sis_regs_t;

endpackage

// File: rtl/sis_stat_pack.sv
module sis_stat_pack (
    input  logic [4:0] flags,
    input  logic       i_now,
    input  logic [5:0] raw6,
    output logic [7:0] hw_byte,
    output logic [7:0] sw_byte,
    output logic [7:0] restored,
    output logic       raw_i
);
    // flags = {N,V,D,Z,C}; raw6 = pulled bits {7,6,3,2,1,0}
    assign hw_byte  = {flags[4:3], 1'b1, 1'b0, flags[2], i_now, flags[1:0]};
    assign sw_byte  = {flags[4:3], 1'b1, 1'b1, flags[2], i_now, flags[1:0]};
    assign restored = {raw6[5:4], 1'b1, 1'b0, raw6[3:0]};
    assign raw_i    = raw6[2];
endmodule

// File: rtl/sis_irq_gate.sv
module sis_irq_gate (
    input  logic idle,
    input  logic boundary,
    input  logic irq,
    input  logic i_now,
    input  logic i_old,
    input  logic dly,
    output logic take
);
    logic mask;
    assign mask = dly ? i_old : i_now;
    assign take = idle & boundary & irq & ~mask;
endmodule

// File: rtl/stack_irq_seq.sv
module stack_irq_seq #(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [7:0]  RESET_SP   = 8'hFD,
    parameter logic [15:0] VEC_RESET  = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [3:0]  cmd_op,
    input  logic [15:0] cmd_target,
    input  logic [7:0]  cmd_data,
    input  logic [15:0] pc_in,
    input  logic [4:0]  flags_in,
    input  logic        irq,
    input  logic        boundary,
    input  logic [7:0]  mem_rdata,
    output logic        busy,
    output logic [15:0] mem_addr,
    output logic        mem_we,
    output logic [7:0]  mem_wdata,
    output logic        pc_load,
    output logic [15:0] pc_out,
    output logic        status_load,
    output logic [7:0]  status_out,
    output logic        pull_valid,
    output logic [7:0]  pull_data,
    output logic [7:0]  sp,
    output logic        i_flag
);
    import sis_pkg::*;

    localparam logic [15:0] VEC_RESET_HI = VEC_RESET + 16'd1;
    localparam logic [15:0] VEC_IRQ_HI   = VEC_IRQ + 16'd1;

    sis_regs_t q, d;
    sis_op_e   op;
    logic      take;
    logic [7:0] hw_byte, sw_byte, restored;
    logic      raw_i;
    logic [7:0] pop_sp;
    logic [15:0] push_addr, pop_addr;

    assign op        = sis_op_e'(cmd_op);
    assign pop_sp    = q.sp + 8'd1;
    assign push_addr = {STACK_PAGE, q.sp};
    assign pop_addr  = {STACK_PAGE, pop_sp};

    sis_stat_pack u_pack (
        .flags    (flags_in),
        .i_now    (q.i),
        .raw6     ({mem_rdata[7:6], mem_rdata[3:0]}),
        .hw_byte  (hw_byte),
        .sw_byte  (sw_byte),
        .restored (restored),
        .raw_i    (raw_i)
    );

    sis_irq_gate u_gate (
        .idle     (q.st == ST_IDLE),
        .boundary (boundary),
        .irq      (irq),
        .i_now    (q.i),
        .i_old    (q.i_old),
        .dly      (q.dly),
        .take     (take)
    );

    always_comb begin
        d         = q;
        d.pc_load = 1'b0;
        d.st_load = 1'b0;
        d.pull_v  = 1'b0;
        mem_addr  = pc_in;
        mem_we    = 1'b0;
        mem_wdata = 8'h00;
        unique case (q.st)
            ST_IDLE: begin
                if (take) begin
                    d.st        = ST_EN_D1;
                    d.pc_keep   = pc_in;
                    d.byte_keep = hw_byte;
                    d.i         = 1'b1;
                    d.dly       = 1'b0;
                end else begin
                    if (boundary) d.dly = 1'b0;
                    if (cmd_valid) begin
                        case (op)
                            OP_CALL: begin
                                d.pc_keep = pc_in - 16'd1;
                                d.tgt     = cmd_target;
                                d.st      = ST_CL_H;
                            end
                            OP_RSUB: begin d.add1 = 1'b1; d.st = ST_PO_L; end
                            OP_RINT: begin d.add1 = 1'b0; d.st = ST_PO_S; end
                            OP_BRK: begin
                                d.pc_keep   = pc_in + 16'd1;
                                d.byte_keep = sw_byte;
                                d.i         = 1'b1;
                                d.st        = ST_EN_D1;
                            end
                            OP_PUSH: begin d.byte_keep = cmd_data; d.st = ST_PUSH; end
                            OP_PULL:   d.st = ST_PULL;
                            OP_PULLST: d.st = ST_PLP;
                            OP_SETI: begin d.i_old = q.i; d.dly = 1'b1; d.i = 1'b1; end
                            OP_CLRI: begin d.i_old = q.i; d.dly = 1'b1; d.i = 1'b0; end
                            default: ;
                        endcase
                    end
                end
            end
            ST_RV_LO: begin
                mem_addr = VEC_RESET;
                d.lo     = mem_rdata;
                d.st     = ST_RV_HI;
            end
            ST_RV_HI: begin
                mem_addr  = VEC_RESET_HI;
                d.pc_out  = {mem_rdata, q.lo};
                d.pc_load = 1'b1;
                d.st      = ST_IDLE;
            end
            ST_EN_D1: begin
                mem_addr = q.pc_keep;
                d.st     = ST_EN_D2;
            end
            ST_EN_D2: begin
                mem_addr = push_addr;
                d.st     = ST_EN_PH;
            end
            ST_EN_PH, ST_EN_PL, ST_EN_PS, ST_CL_H, ST_CL_L, ST_PUSH: begin
                mem_addr = push_addr;
                mem_we   = 1'b1;
                d.sp     = q.sp - 8'd1;
                case (q.st)
                    ST_EN_PH: begin mem_wdata = q.pc_keep[15:8]; d.st = ST_EN_PL; end
                    ST_EN_PL: begin mem_wdata = q.pc_keep[7:0];  d.st = ST_EN_PS; end
                    ST_EN_PS: begin mem_wdata = q.byte_keep;     d.st = ST_EN_VL; end
                    ST_CL_H:  begin mem_wdata = q.pc_keep[15:8]; d.st = ST_CL_L;  end
                    ST_CL_L: begin
                        mem_wdata = q.pc_keep[7:0];
                        d.pc_out  = q.tgt;
                        d.pc_load = 1'b1;
                        d.st      = ST_IDLE;
                    end
                    default: begin mem_wdata = q.byte_keep; d.st = ST_IDLE; end
                endcase
            end
            ST_EN_VL: begin
                mem_addr = VEC_IRQ;
                d.lo     = mem_rdata;
                d.st     = ST_EN_VH;
            end
            ST_EN_VH: begin
                mem_addr  = VEC_IRQ_HI;
                d.pc_out  = {mem_rdata, q.lo};
                d.pc_load = 1'b1;
                d.st      = ST_IDLE;
            end
            ST_PO_S, ST_PO_L, ST_PO_H, ST_PULL, ST_PLP: begin
                mem_addr = pop_addr;
                d.sp     = pop_sp;
                case (q.st)
                    ST_PO_S: begin
                        d.st_out  = restored;
                        d.st_load = 1'b1;
                        d.i       = raw_i;
                        d.st      = ST_PO_L;
                    end
                    ST_PO_L: begin d.lo = mem_rdata; d.st = ST_PO_H; end
                    ST_PO_H: begin
                        d.pc_out  = {mem_rdata, q.lo} + {15'd0, q.add1};
                        d.pc_load = 1'b1;
                        d.st      = ST_IDLE;
                    end
                    ST_PULL: begin
                        d.pull_d = mem_rdata;
                        d.pull_v = 1'b1;
                        d.st     = ST_IDLE;
                    end
                    default: begin
                        d.st_out  = restored;
                        d.st_load = 1'b1;
                        d.i_old   = q.i;
                        d.dly     = 1'b1;
                        d.i       = raw_i;
                        d.st      = ST_IDLE;
                    end
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_RV_LO;
            q.sp <= RESET_SP;
            q.i  <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy        = (q.st != ST_IDLE);
    assign pc_load     = q.pc_load;
    assign pc_out      = q.pc_out;
    assign status_load = q.st_load;
    assign status_out  = q.st_out;
    assign pull_valid  = q.pull_v;
    assign pull_data   = q.pull_d;
    assign sp          = q.sp;
    assign i_flag      = q.i;

endmodule

// File: rtl/sis_chk.sv
module sis_chk #(
    parameter logic [7:0] STACK_PAGE = 8'h01
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       mem_we,
    input logic [7:0] hi_addr,
    input logic [7:0] sp,
    input logic       pc_load,
    input logic       status_load,
    input logic [1:0] st_fix
);
    AST_WRITE_IN_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> hi_addr == STACK_PAGE);                              // R1
    AST_WRITE_THEN_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> sp == $past(sp) - 8'd1);                             // R1
    AST_IDLE_SP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> sp == $past(sp));                                     // R1
    AST_PC_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> !busy);                                             // R2
    AST_RESTORE_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        status_load |-> st_fix == 2'b10);                               // R8
endmodule

bind stack_irq_seq sis_chk #(.STACK_PAGE(STACK_PAGE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .mem_we      (mem_we),
    .hi_addr     (mem_addr[15:8]),
    .sp          (sp),
    .pc_load     (pc_load),
    .status_load (status_load),
    .st_fix      (status_out[5:4])
);

// File: tb/sim_stack_irq_seq.sv
module sim_stack_irq_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic [15:0] cmd_target = 16'd0;
    logic [7:0]  cmd_data = 8'd0;
    logic [15:0] pc_in = 16'h4000;
    logic [4:0]  flags_in = 5'd0;
    logic        irq = 1'b0;
    logic        boundary = 1'b0;
    logic [7:0]  mem_rdata;
    logic        busy, mem_we, pc_load, status_load, pull_valid, i_flag;
    logic [15:0] mem_addr, pc_out;
    logic [7:0]  mem_wdata, status_out, pull_data, sp;

    always #10 clk = ~clk;

    stack_irq_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_target(cmd_target), .cmd_data(cmd_data), .pc_in(pc_in),
        .flags_in(flags_in), .irq(irq), .boundary(boundary),
        .mem_rdata(mem_rdata), .busy(busy), .mem_addr(mem_addr),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_out(pc_out), .status_load(status_load), .status_out(status_out),
        .pull_valid(pull_valid), .pull_data(pull_data), .sp(sp), .i_flag(i_flag)
    );

    logic [7:0] stk [256];
    always @(posedge clk) if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
    always_comb begin
        if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
        else case (mem_addr)
            16'hFFFC: mem_rdata = 8'h00;
            16'hFFFD: mem_rdata = 8'h80;
            16'hFFFE: mem_rdata = 8'h34;
            16'hFFFF: mem_rdata = 8'h12;
            default:  mem_rdata = mem_addr[7:0] ^ 8'h5A;
        endcase
    end

    int checks = 0, fails = 0, ncyc, nwr;
    logic done = 1'b0;
    logic [15:0] wa [8];
    logic [7:0]  wd [8];
    int          wc [8];
    logic        st_seen, got_pcl, got_pv;
    logic [7:0]  st_val, got_pd, esp, expv [256];
    logic [15:0] got_pc;
    logic        ei;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [3:0] op, input logic b, input logic iv,
                       input logic [15:0] pc, input logic [15:0] tg,
                       input logic [7:0] dat, input logic [4:0] fl);
        @(negedge clk);
        cmd_valid = (op != 4'd0); cmd_op = op; boundary = b; irq = iv;
        pc_in = pc; cmd_target = tg; cmd_data = dat; flags_in = fl;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 4'd0; boundary = 1'b0; irq = 1'b0;
        ncyc = 0; nwr = 0; st_seen = 1'b0;
        while (busy === 1'b1 && ncyc < 40) begin
            if (mem_we && nwr < 8) begin
                wa[nwr] = mem_addr; wd[nwr] = mem_wdata; wc[nwr] = ncyc; nwr++;
            end
            if (status_load) begin st_seen = 1'b1; st_val = status_out; end
            ncyc++;
            @(negedge clk);
        end
        if (status_load) begin st_seen = 1'b1; st_val = status_out; end
        got_pcl = pc_load; got_pc = pc_out; got_pv = pull_valid; got_pd = pull_data;
    endtask

    task automatic op_only(input logic [3:0] op, input logic [7:0] dat);
        run(op, 1'b0, 1'b0, 16'h4000, 16'h0000, dat, 5'd0);
    endtask

    task automatic bnd(input logic iv);
        run(4'd0, 1'b1, iv, 16'h4000, 16'h0000, 8'd0, 5'd0);
    endtask

    task automatic chk_none(input string tg);
        chk({tg, " no entry"}, ncyc, 0);
        chk({tg, " sp held"}, sp, esp);
    endtask

    task automatic chk_entry(input string tg, input logic [15:0] pcp, input logic [7:0] stv);
        chk({tg, " cycles"}, ncyc, 7);
        chk({tg, " writes"}, nwr, 3);
        chk({tg, " first write cycle"}, wc[0], 2);
        chk({tg, " addr hi"}, wa[0], {8'h01, esp});
        chk({tg, " addr lo"}, wa[1], {8'h01, 8'(esp - 8'd1)});
        chk({tg, " addr st"}, wa[2], {8'h01, 8'(esp - 8'd2)});
        chk({tg, " data hi"}, wd[0], pcp[15:8]);
        chk({tg, " data lo"}, wd[1], pcp[7:0]);
        chk({tg, " data st"}, wd[2], stv);
        chk({tg, " vector"}, {got_pcl, got_pc}, {1'b1, 16'h1234});
        esp = esp - 8'd3;
        chk({tg, " sp"}, sp, esp);
        chk({tg, " I set"}, i_flag, 1);
        ei = 1'b1;
    endtask

    function automatic logic [7:0] pk(input logic [4:0] f, input logic i, input logic b);
        return {f[4:3], 1'b1, b, f[2], i, f[1:0]};
    endfunction

    task automatic clear_i();
        op_only(4'd9, 8'd0);
        bnd(1'b0);
        ei = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 256; k++) stk[k] = 8'h00;
        repeat (3) @(negedge clk);
        // R2 reset state
        chk("R2 reset sp", sp, 8'hFD);
        chk("R2 reset I", i_flag, 1);
        chk("R2 reset busy", busy, 1);
        chk("R2 reset vec lo addr", mem_addr, 16'hFFFC);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2 vec hi addr", mem_addr, 16'hFFFD);
        @(negedge clk);
        chk("R2 reset pc", {busy, pc_load, pc_out}, {1'b0, 1'b1, 16'h8000});
        esp = 8'hFD; ei = 1'b1;

        // R11: masked request
        bnd(1'b1); chk_none("R11 I set");
        // R10: clear I from set; first boundary still masked
        op_only(4'd9, 8'd0); ei = 1'b0;
        bnd(1'b1); chk_none("R10 clear-I delay");
        bnd(1'b1); chk_entry("R10 clear-I later", 16'h4000, pk(5'd0, 1'b0, 1'b0));

        clear_i();
        run(4'd0, 1'b0, 1'b1, 16'h4000, 0, 0, 0); chk_none("R11 no boundary");
        bnd(1'b0); chk_none("R11 irq low");

        // R3 R5 hardware entry over flag patterns
        for (int k = 0; k < 32; k++) begin
            logic [15:0] p;
            p = 16'(k * 16'h0811 + 16'h0101);
            run(4'd0, 1'b1, 1'b1, p, 0, 0, 5'(k));
            chk_entry("R3 R5 hw entry", p, pk(5'(k), 1'b0, 1'b0));
            clear_i();
        end

        // R10 set I from clear: next boundary uses old (clear)
        op_only(4'd8, 8'd0); ei = 1'b1;
        bnd(1'b1); chk_entry("R10 set-I delay", 16'h4000, pk(5'd0, 1'b1, 1'b0));
        op_only(4'd8, 8'd0);
        bnd(1'b1); chk_none("R10 set-I from set");
        bnd(1'b1); chk_none("R11 still masked");

        // R11 entry beats a same-cycle command
        clear_i();
        run(4'd5, 1'b1, 1'b1, 16'h4000, 0, 8'hAA, 5'd0);
        chk_entry("R11 entry wins", 16'h4000, pk(5'd0, 1'b0, 1'b0));

        // R12 pull status clearing I, with delay
        op_only(4'd5, 8'h00); esp = esp - 8'd1;
        op_only(4'd7, 8'd0); esp = esp + 8'd1;
        chk("R12 plp cycles", ncyc, 1);
        chk("R12 plp status", {st_seen, st_val}, {1'b1, 8'h20});
        chk("R12 plp I", i_flag, 0);
        chk("R12 plp sp", sp, esp);
        bnd(1'b1); chk_none("R10 plp old set");
        bnd(1'b1); chk_entry("R10 plp later", 16'h4000, pk(5'd0, 1'b0, 1'b0));
        clear_i();
        op_only(4'd5, 8'h04); esp = esp - 8'd1;
        op_only(4'd7, 8'd0); esp = esp + 8'd1;
        chk("R12 plp I from bit2", i_flag, 1);
        bnd(1'b1); chk_entry("R10 plp old clear", 16'h4000, pk(5'd0, 1'b1, 1'b0));

        // R1 R9 push sweep through wrap, then pull back
        for (int k = 0; k < 256; k++) begin
            logic [7:0] v;
            v = 8'(k * 37 + 5);
            op_only(4'd5, v);
            chk("R9 push cycles", ncyc, 1);
            chk("R1 push addr", wa[0], {8'h01, esp});
            chk("R9 push data", wd[0], v);
            expv[esp] = v;
            esp = esp - 8'd1;
            chk("R1 push sp", sp, esp);
        end
        for (int k = 0; k < 256; k++) begin
            op_only(4'd6, 8'd0);
            esp = esp + 8'd1;
            chk("R9 pull data", {got_pv, got_pd}, {1'b1, expv[esp]});
            chk("R1 pull sp", sp, esp);
        end

        // R4 R5 break sweep
        for (int k = 0; k < 64; k++) begin
            logic [15:0] p;
            p = (k == 63) ? 16'hFFFF : 16'(k * 16'h0409 + 16'h00FF);
            run(4'd4, 1'b0, 1'b0, p, 0, 0, 5'(k ^ 21));
            chk_entry("R4 R5 break", p + 16'd1, pk(5'(k ^ 21), 1'b1, 1'b1));
        end

        // R6 R7 call and return round trips
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p, m;
            case (k)
                0: p = 16'h0000; 1: p = 16'h0001; 2: p = 16'h00FF; 3: p = 16'h0100;
                4: p = 16'h8000; 5: p = 16'hFFFF; 6: p = 16'h1234; default: p = 16'hA5F0;
            endcase
            m = p - 16'd1;
            run(4'd1, 1'b0, 1'b0, p, p ^ 16'h5A5A, 0, 0);
            chk("R6 call cycles", ncyc, 2);
            chk("R6 call hi", {wa[0], wd[0]}, {8'h01, esp, m[15:8]});
            chk("R6 call lo", {wa[1], wd[1]}, {8'h01, 8'(esp - 8'd1), m[7:0]});
            chk("R6 call target", {got_pcl, got_pc}, {1'b1, p ^ 16'h5A5A});
            esp = esp - 8'd2;
            op_only(4'd2, 8'd0);
            esp = esp + 8'd2;
            chk("R7 rts cycles", {ncyc, nwr}, {32'd2, 32'd0});
            chk("R7 rts pc", {got_pcl, got_pc}, {1'b1, p});
            chk("R7 rts sp", sp, esp);
        end

        // R8 interrupt return
        for (int k = 0; k < 6; k++) begin
            logic [7:0] s;
            case (k)
                0: s = 8'h00; 1: s = 8'hFF; 2: s = 8'h30; 3: s = 8'hCF; 4: s = 8'h04; default: s = 8'h5A;
            endcase
            op_only(4'd5, 8'h9A ^ 8'(k));
            op_only(4'd5, 8'hBC);
            op_only(4'd5, s);
            esp = esp - 8'd3;
            op_only(4'd3, 8'd0);
            esp = esp + 8'd3;
            chk("R8 rti cycles", ncyc, 3);
            chk("R8 rti status", {st_seen, st_val}, {1'b1, s[7:6], 2'b10, s[3:0]});
            chk("R8 rti pc", {got_pcl, got_pc}, {1'b1, 8'h9A ^ 8'(k), 8'hBC});
            chk("R8 rti I", i_flag, s[2]);
            chk("R8 rti sp", sp, esp);
            ei = s[2];
            bnd(1'b1);
            if (s[2] == 1'b0) chk_entry("R8 rti no delay", 16'h4000, pk(5'd0, 1'b0, 1'b0));
            else chk_none("R8 rti restored set");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule